// File: doc/BRIEF.md
# Priority-Level Interrupt Dispatch Unit

This block sits beside a processor's exception logic and decides, once per clock, whether the interrupt level already chosen by an upstream priority encoder may be taken. It judges the pending level against the processor's current interrupt level and against the per-level source masks. The masks are combined with the raw interrupt-set and interrupt-enable vectors. When the level is accepted, the block updates the exception state registers in the same clock edge and emits a one-cycle taken pulse.

Levels of two and above are treated as high-priority interrupts. Each of these saves the program counter and status word into registers owned by that level, raises the status interrupt-level field and jumps to a vector assigned to that level. Level 1 is handled differently. It is converted into a general exception: kernel, user or double, depending on the status bits. It records a fixed cause code and jumps to the matching exception vector. Every vector can be relocated at run time through a programmable vector-base input.

Top module: `irq_dispatch`

## Requirements
- R1: An interrupt is accepted only when the pending level is at least 1, is at most NLEVEL, is strictly above the current interrupt level, and the bitwise AND of that level's mask (slice `(L-1)*NINT` of `lvl_mask`) with `int_set` and `int_en` is nonzero.
- R2: The current interrupt level is the status field at bits [3:0]. When the status EXCM bit (bit 4) is set and that field is below EXCM_LEVEL, the current level is raised to EXCM_LEVEL.
- R3: When a level L of 2 or more is accepted, the following happens. The PC is saved into slice L-1 of `epc_flat`. The status word is saved into slice L-2 of `eps_flat`. `new_ps` becomes the old status with bits [3:0] replaced by L, bit 4 set and all other bits kept. `new_pc` becomes the level-L vector, at offset L*LVL_STRIDE.
- R4: When level 1 is accepted, `exccause` becomes L1_CAUSE (default 4), and `new_ps` becomes the old status with bit 4 set.
- R5: When level 1 is accepted with EXCM clear, the PC is saved into slice 0 of `epc_flat`. `new_pc` becomes the user vector (offset USER_OFF) if the UM bit (bit 5) is set, and the kernel vector (offset KERN_OFF) if it is clear.
- R6: When level 1 is accepted with EXCM set, `new_pc` becomes the double-exception vector (offset DBL_OFF). The PC is saved into `depc` when HAS_DEPC is 1, and into slice 0 of `epc_flat` otherwise. `depc` stays 0 when HAS_DEPC is 0.
- R7: With RELOC=1, every target is `vecbase` plus the vector's offset. This equals the fixed vector, minus DEF_VECBASE, plus `vecbase`. With RELOC=0, every target is DEF_VECBASE plus the offset.
- R8: `taken` is high for exactly the one cycle after each accepted interrupt. When no interrupt is accepted, `new_pc`, `new_ps`, `exccause`, `depc`, `epc_flat` and `eps_flat` keep their values.
- R9: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_level | input | 4 | Pending interrupt level from the priority encoder (0 means none) |
| int_set | input | NINT | Raw asserted interrupt sources |
| int_en | input | NINT | Interrupt enable vector |
| lvl_mask | input | NLEVEL*NINT | Per-level source masks, level L at slice L-1 |
| cur_pc | input | XLEN | Current program counter |
| cur_ps | input | XLEN | Current status word |
| vecbase | input | XLEN | Programmable vector base |
| new_pc | output | XLEN | Redirect target of the last accepted interrupt |
| new_ps | output | XLEN | Status word after the last accepted interrupt |
| taken | output | 1 | One-cycle pulse per accepted interrupt |
| epc_flat | output | NLEVEL*XLEN | Saved PC per level, level L at slice L-1 |
| eps_flat | output | (NLEVEL-1)*XLEN | Saved status for levels 2..NLEVEL, level L at slice L-2 |
| depc | output | XLEN | Saved PC of a double exception |
| exccause | output | XLEN | Exception cause register |

## Verification
The double-exception route is the hardest case to reach from the ports. It needs a level-1 interrupt accepted while EXCM is set. With any EXCM_LEVEL of 1 or more, EXCM itself masks level 1, so the route cannot occur in the default configuration. The bench therefore runs two further instances with EXCM_LEVEL=0 beside the default one: one that has the double-exception PC register and one that lacks it. The relocation option is also varied across the instances. All three are fed the same randomised stream, in which EXCM is set often and levels 1..NLEVEL are pending often. Each instance is compared every cycle against a behavioural model carrying that instance's options.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

   localparam int IL_W    = 4;   // width of the status interrupt-level field
   localparam int PS_IL_LSB = 0;
   localparam int PS_EXCM = 4;
   localparam int PS_UM   = 5;

   typedef enum logic [1:0] {
      ROUTE_KERN = 2'd0,
      ROUTE_USER = 2'd1,
      ROUTE_DBL  = 2'd2,
      ROUTE_HIGH = 2'd3
   } route_e;

   function automatic route_e route_of(input logic [IL_W-1:0] lvl,
                                       input logic excm, input logic um);
      if (lvl >= IL_W'(2)) return ROUTE_HIGH;
      else if (excm)       return ROUTE_DBL;
      else if (um)         return ROUTE_USER;
      else                 return ROUTE_KERN;
   endfunction

endpackage

// File: rtl/irq_accept.sv
module irq_accept
   import irq_disp_pkg::*;
#(
   parameter int NLEVEL     = 6,
   parameter int NINT       = 32,
   parameter int EXCM_LEVEL = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [IL_W-1:0]        pend_level,
   input  logic [IL_W-1:0]        ps_intlevel,
   input  logic                   ps_excm,
   input  logic [NINT-1:0]        int_set,
   input  logic [NINT-1:0]        int_en,
   input  logic [NLEVEL*NINT-1:0] lvl_mask,
   output logic                   accept
);
   localparam logic [IL_W-1:0] EXCM_L = IL_W'(EXCM_LEVEL);

   logic [NINT-1:0]   live;
   logic [NLEVEL:0]   lvl_hit;
   logic              sel_hit;
   logic [IL_W-1:0]   cur_lvl;

   assign live       = int_set & int_en;
   assign lvl_hit[0] = 1'b0;

   for (genvar l = 1; l <= NLEVEL; l++) begin : g_lvl
      assign lvl_hit[l] = |(lvl_mask[(l-1)*NINT +: NINT] & live);
   end

   always_comb begin
      sel_hit = 1'b0;
      for (int l = 1; l <= NLEVEL; l++)
         if (pend_level == IL_W'(l)) sel_hit = lvl_hit[l];
   end

   always_comb begin
      cur_lvl = ps_intlevel;
      if (ps_excm && (ps_intlevel < EXCM_L)) cur_lvl = EXCM_L;
   end

   assign accept = sel_hit && (pend_level > cur_lvl);

   // R1: an accepted level lies above the raw status level and within range
   p_above_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (pend_level > ps_intlevel) && (pend_level <= IL_W'(NLEVEL)) && (pend_level != '0));
   // R1: some enabled, asserted source must exist
   p_live_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (int_set & int_en) != '0);
   // R2: with EXCM set, nothing at or below EXCM_LEVEL gets through
   p_excm_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ps_excm) |-> (pend_level > EXCM_L));

endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel
   import irq_disp_pkg::*;
#(
   parameter int           XLEN        = 32,
   parameter bit           RELOC       = 1'b1,
   parameter logic [31:0]  DEF_VECBASE = 32'h4000_0000,
   parameter logic [31:0]  LVL_STRIDE  = 32'h40,
   parameter logic [31:0]  KERN_OFF    = 32'h300,
   parameter logic [31:0]  USER_OFF    = 32'h340,
   parameter logic [31:0]  DBL_OFF     = 32'h3C0
) (
   input  logic [IL_W-1:0] level,
   input  route_e          route,
   input  logic [XLEN-1:0] vecbase,
   output logic [XLEN-1:0] target
);
   logic [XLEN-1:0] base;
   logic [XLEN-1:0] offset;

   if (RELOC) begin : g_reloc
      assign base = vecbase;
   end else begin : g_fixed
      assign base = XLEN'(DEF_VECBASE);
   end

   always_comb begin
      unique case (route)
         ROUTE_HIGH: offset = XLEN'(level) * XLEN'(LVL_STRIDE);
         ROUTE_DBL:  offset = XLEN'(DBL_OFF);
         ROUTE_USER: offset = XLEN'(USER_OFF);
         default:    offset = XLEN'(KERN_OFF);
      endcase
   end

   assign target = base + offset;

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
   import irq_disp_pkg::*;
#(
   parameter int           XLEN        = 32,
   parameter int           NINT        = 32,
   parameter int           NLEVEL      = 6,
   parameter int           EXCM_LEVEL  = 1,
   parameter bit           HAS_DEPC    = 1'b1,
   parameter bit           RELOC       = 1'b1,
   parameter logic [31:0]  DEF_VECBASE = 32'h4000_0000,
   parameter logic [31:0]  LVL_STRIDE  = 32'h40,
   parameter logic [31:0]  KERN_OFF    = 32'h300,
   parameter logic [31:0]  USER_OFF    = 32'h340,
   parameter logic [31:0]  DBL_OFF     = 32'h3C0,
   parameter int           L1_CAUSE    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [IL_W-1:0]            pend_level,
   input  logic [NINT-1:0]            int_set,
   input  logic [NINT-1:0]            int_en,
   input  logic [NLEVEL*NINT-1:0]     lvl_mask,
   input  logic [XLEN-1:0]            cur_pc,
   input  logic [XLEN-1:0]            cur_ps,
   input  logic [XLEN-1:0]            vecbase,
   output logic [XLEN-1:0]            new_pc,
   output logic [XLEN-1:0]            new_ps,
   output logic                       taken,
   output logic [NLEVEL*XLEN-1:0]     epc_flat,
   output logic [(NLEVEL-1)*XLEN-1:0] eps_flat,
   output logic [XLEN-1:0]            depc,
   output logic [XLEN-1:0]            exccause
);
   localparam logic [XLEN-1:0] IL_FIELD = XLEN'((1 << IL_W) - 1) << PS_IL_LSB;
   localparam logic [XLEN-1:0] EXCM_BIT = XLEN'(1) << PS_EXCM;

   if (NLEVEL < 2 || NLEVEL >= (1 << IL_W)) begin : g_bad_nlevel
      $error("irq_dispatch: NLEVEL must lie in 2..%0d", (1 << IL_W) - 1);
   end
   if (EXCM_LEVEL < 0 || EXCM_LEVEL > NLEVEL) begin : g_bad_excm
      $error("irq_dispatch: EXCM_LEVEL must lie in 0..NLEVEL");
   end
   if (XLEN < 8 || NINT < 1) begin : g_bad_width
      $error("irq_dispatch: XLEN must be at least 8 and NINT at least 1");
   end

   logic            accept;
   route_e          route;
   logic [XLEN-1:0] target;
   logic [XLEN-1:0] ps_hi;

   logic [XLEN-1:0] epc_q [1:NLEVEL];
   logic [XLEN-1:0] eps_q [2:NLEVEL];
   logic [XLEN-1:0] new_pc_q, new_ps_q, depc_q, cause_q;
   logic            taken_q;

   irq_accept #(
      .NLEVEL(NLEVEL), .NINT(NINT), .EXCM_LEVEL(EXCM_LEVEL)
   ) u_accept (
      .clk(clk), .rst_n(rst_n),
      .pend_level(pend_level),
      .ps_intlevel(cur_ps[PS_IL_LSB +: IL_W]),
      .ps_excm(cur_ps[PS_EXCM]),
      .int_set(int_set), .int_en(int_en), .lvl_mask(lvl_mask),
      .accept(accept)
   );

   assign route = route_of(pend_level, cur_ps[PS_EXCM], cur_ps[PS_UM]);

   irq_vec_sel #(
      .XLEN(XLEN), .RELOC(RELOC), .DEF_VECBASE(DEF_VECBASE),
      .LVL_STRIDE(LVL_STRIDE), .KERN_OFF(KERN_OFF),
      .USER_OFF(USER_OFF), .DBL_OFF(DBL_OFF)
   ) u_vec (
      .level(pend_level), .route(route), .vecbase(vecbase), .target(target)
   );

   assign ps_hi = (cur_ps & ~IL_FIELD) | (XLEN'(pend_level) << PS_IL_LSB) | EXCM_BIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         new_pc_q <= '0;
         new_ps_q <= '0;
         depc_q   <= '0;
         cause_q  <= '0;
         taken_q  <= 1'b0;
         for (int l = 1; l <= NLEVEL; l++) epc_q[l] <= '0;
         for (int l = 2; l <= NLEVEL; l++) eps_q[l] <= '0;
      end else begin
         taken_q <= accept;
         if (accept) begin
            new_pc_q <= target;
            if (route == ROUTE_HIGH) begin
               new_ps_q <= ps_hi;
               for (int l = 2; l <= NLEVEL; l++) begin
                  if (pend_level == IL_W'(l)) begin
                     epc_q[l] <= cur_pc;
                     eps_q[l] <= cur_ps;
                  end
               end
            end else begin
               cause_q  <= XLEN'(L1_CAUSE);
               new_ps_q <= cur_ps | EXCM_BIT;
               if (route == ROUTE_DBL && HAS_DEPC) depc_q   <= cur_pc;
               else                                epc_q[1] <= cur_pc;
            end
         end
      end
   end

   for (genvar l = 1; l <= NLEVEL; l++) begin : g_epc_out
      assign epc_flat[(l-1)*XLEN +: XLEN] = epc_q[l];
   end
   for (genvar l = 2; l <= NLEVEL; l++) begin : g_eps_out
      assign eps_flat[(l-2)*XLEN +: XLEN] = eps_q[l];
   end

   assign new_pc   = new_pc_q;
   assign new_ps   = new_ps_q;
   assign depc     = depc_q;
   assign exccause = cause_q;
   assign taken    = taken_q;

   // R8: a refused cycle leaves every architectural register alone
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(new_pc) && $stable(new_ps) && $stable(exccause)
                  && $stable(depc) && $stable(epc_flat) && $stable(eps_flat));
   // R8: the pulse follows an acceptance by one edge
   p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> taken);
   // R3: the status field carries the accepted high level
   p_level_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pend_level >= IL_W'(2)) |=>
         new_ps[PS_IL_LSB +: IL_W] == $past(pend_level) && new_ps[PS_EXCM]);
   // R3: bits outside the level field and EXCM survive
   p_keep_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ((new_ps ^ $past(cur_ps)) & ~(IL_FIELD | EXCM_BIT)) == '0);
   // R4: level 1 records its cause and sets EXCM
   p_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pend_level == IL_W'(1)) |=>
         exccause == XLEN'(L1_CAUSE) && new_ps[PS_EXCM]);
   // R6: without a double-exception register it never moves
   p_no_depc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !HAS_DEPC |-> depc == '0);

endmodule

// File: tb/tb_irq_dispatch.sv
module tb_irq_dispatch;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 32, NINT = 32, NLEV = 6, NI = 3;
   localparam logic [31:0] DEFVB = 32'h4000_0000;

   // per-instance options: 0 = defaults, 1 = EXCM_LEVEL 0 with depc, no reloc,
   // 2 = EXCM_LEVEL 0 without depc, reloc
   int cfg_excml [NI] = '{1, 0, 0};
   bit cfg_depc  [NI] = '{1, 1, 0};
   bit cfg_reloc [NI] = '{1, 0, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] pend_level = '0;
   logic [NINT-1:0] int_set = '0, int_en = '0;
   logic [NLEV*NINT-1:0] lvl_mask = '0;
   logic [XLEN-1:0] cur_pc = '0, cur_ps = '0, vecbase = '0;

   logic [XLEN-1:0] o_pc [NI], o_ps [NI], o_depc [NI], o_cause [NI];
   logic            o_tk [NI];
   logic [NLEV*XLEN-1:0]     o_epc [NI];
   logic [(NLEV-1)*XLEN-1:0] o_eps [NI];

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_dispatch dut (
      .clk(clk), .rst_n(rst_n), .pend_level(pend_level), .int_set(int_set),
      .int_en(int_en), .lvl_mask(lvl_mask), .cur_pc(cur_pc), .cur_ps(cur_ps),
      .vecbase(vecbase), .new_pc(o_pc[0]), .new_ps(o_ps[0]), .taken(o_tk[0]),
      .epc_flat(o_epc[0]), .eps_flat(o_eps[0]), .depc(o_depc[0]), .exccause(o_cause[0]));

   irq_dispatch #(.EXCM_LEVEL(0), .HAS_DEPC(1'b1), .RELOC(1'b0)) dut_d (
      .clk(clk), .rst_n(rst_n), .pend_level(pend_level), .int_set(int_set),
      .int_en(int_en), .lvl_mask(lvl_mask), .cur_pc(cur_pc), .cur_ps(cur_ps),
      .vecbase(vecbase), .new_pc(o_pc[1]), .new_ps(o_ps[1]), .taken(o_tk[1]),
      .epc_flat(o_epc[1]), .eps_flat(o_eps[1]), .depc(o_depc[1]), .exccause(o_cause[1]));

   irq_dispatch #(.EXCM_LEVEL(0), .HAS_DEPC(1'b0), .RELOC(1'b1)) dut_e (
      .clk(clk), .rst_n(rst_n), .pend_level(pend_level), .int_set(int_set),
      .int_en(int_en), .lvl_mask(lvl_mask), .cur_pc(cur_pc), .cur_ps(cur_ps),
      .vecbase(vecbase), .new_pc(o_pc[2]), .new_ps(o_ps[2]), .taken(o_tk[2]),
      .epc_flat(o_epc[2]), .eps_flat(o_eps[2]), .depc(o_depc[2]), .exccause(o_cause[2]));

   // behavioural reference state
   logic [31:0] m_pc [NI], m_ps [NI], m_depc [NI], m_cause [NI];
   logic        m_tk [NI];
   logic [31:0] m_epc [NI][NLEV+1];
   logic [31:0] m_eps [NI][NLEV+1];
   int n_dbl = 0, n_high = 0, n_l1 = 0;

   function automatic logic [31:0] vec_of(int i, int lvl, bit excm, bit um, logic [31:0] vb);
      logic [31:0] off;
      if (lvl >= 2)  off = 32'(lvl) * 32'h40;
      else if (excm) off = 32'h3C0;
      else if (um)   off = 32'h340;
      else           off = 32'h300;
      return (cfg_reloc[i] ? vb : DEFVB) + off;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NI; i++) begin
         m_pc[i] = 0; m_ps[i] = 0; m_depc[i] = 0; m_cause[i] = 0; m_tk[i] = 0;
         for (int l = 0; l <= NLEV; l++) begin m_epc[i][l] = 0; m_eps[i][l] = 0; end
      end
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         for (int i = 0; i < NI; i++) begin
            int lvl, cur;
            bit ok, excm;
            lvl  = int'(pend_level);
            excm = cur_ps[4];
            cur  = int'(cur_ps[3:0]);
            if (excm && cur < cfg_excml[i]) cur = cfg_excml[i];
            ok = (lvl >= 1) && (lvl <= NLEV) && (lvl > cur) &&
                 ((lvl_mask[(lvl-1)*NINT +: NINT] & int_set & int_en) != 0);
            m_tk[i] = ok;
            if (ok) begin
               m_pc[i] = vec_of(i, lvl, excm, cur_ps[5], vecbase);
               if (lvl >= 2) begin
                  m_epc[i][lvl] = cur_pc;
                  m_eps[i][lvl] = cur_ps;
                  m_ps[i] = (cur_ps & ~32'hF) | 32'(lvl) | 32'h10;
                  if (i == 0) n_high++;
               end else begin
                  m_cause[i] = 32'd4;
                  m_ps[i] = cur_ps | 32'h10;
                  if (excm) begin
                     if (i == 1) n_dbl++;
                     if (cfg_depc[i]) m_depc[i] = cur_pc;
                     else             m_epc[i][1] = cur_pc;
                  end else begin
                     m_epc[i][1] = cur_pc;
                     if (i == 0) n_l1++;
                  end
               end
            end
         end
      end
   end

   task automatic chk(string tag, int i, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s inst %0d cycle %0d: got %h expected %h", tag, i, cyc, got, exp);
      end
   endtask

   task automatic compare_all();
      for (int i = 0; i < NI; i++) begin
         chk("R1/R2/R8 taken", i, 32'(o_tk[i]), 32'(m_tk[i]));
         chk("R3/R5/R6/R7 new_pc", i, o_pc[i], m_pc[i]);
         chk("R2/R3/R4 new_ps", i, o_ps[i], m_ps[i]);
         chk("R4 exccause", i, o_cause[i], m_cause[i]);
         chk("R6 depc", i, o_depc[i], m_depc[i]);
         for (int l = 1; l <= NLEV; l++)
            chk("R3/R5/R6 epc", i, o_epc[i][(l-1)*XLEN +: XLEN], m_epc[i][l]);
         for (int l = 2; l <= NLEV; l++)
            chk("R3 eps", i, o_eps[i][(l-2)*XLEN +: XLEN], m_eps[i][l]);
      end
   endtask

   task automatic drive_random();
      int r;
      r = int'($urandom_range(0, 19));
      if (r < 2) pend_level = 4'(0);
      else if (r < 4) pend_level = 4'($urandom_range(7, 15));
      else if (r < 10) pend_level = 4'd1;
      else pend_level = 4'($urandom_range(2, 6));
      int_set = ($urandom_range(0, 9) == 0) ? '0 : $urandom();
      int_en  = ($urandom_range(0, 9) == 0) ? '0 : ($urandom() | $urandom());
      cur_pc  = $urandom();
      cur_ps  = $urandom() & 32'hFFFF_FFC0;
      cur_ps[3:0] = 4'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) cur_ps[3:0] = 4'($urandom_range(4, 15));
      cur_ps[4] = ($urandom_range(0, 2) == 0);
      cur_ps[5] = $urandom_range(0, 1) == 1;
      vecbase = $urandom() & 32'hFFFF_F000;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // level masks: nibble per level plus bit 31; level 3 has an empty mask
      for (int l = 1; l <= NLEV; l++)
         lvl_mask[(l-1)*NINT +: NINT] = (l == 3) ? 32'h0 : ((32'hF << (4*(l-1))) | 32'h8000_0000);
      // R9: hold reset with busy inputs, outputs must read zero
      pend_level = 4'd5; int_set = '1; int_en = '1; cur_pc = 32'h1234_5678;
      repeat (3) @(negedge clk);
      compare_all();  // R9 reset state
      for (int i = 0; i < NI; i++) chk("R9 reset taken", i, 32'(o_tk[i]), 32'd0);
      rst_n = 1'b1;
      pend_level = 4'd0;
      @(negedge clk);
      compare_all();
      // directed: level 3 with empty mask must be refused (R1)
      pend_level = 4'd3; cur_ps = 32'h0; int_set = '1; int_en = '1;
      @(negedge clk); compare_all();
      for (int i = 0; i < NI; i++) chk("R1 empty mask", i, 32'(o_tk[i]), 32'd0);
      // directed: level 2 at level 2 refused, level 5 accepted (R1, R3)
      pend_level = 4'd2; cur_ps = 32'h2;
      @(negedge clk); compare_all();
      pend_level = 4'd5; cur_pc = 32'hCAFE_0000; vecbase = 32'h8000_0000;
      @(negedge clk); compare_all();
      for (int i = 0; i < NI; i++) chk("R3 level5 pulse", i, 32'(o_tk[i]), 32'd1);
      // directed: EXCM set, intlevel 0, level 1 -> double on inst 1/2 only (R2, R6)
      pend_level = 4'd1; cur_ps = 32'h10; cur_pc = 32'h0BAD_0001;
      @(negedge clk); compare_all();
      chk("R2 excm masks l1", 0, 32'(o_tk[0]), 32'd0);
      chk("R6 depc kept", 1, o_depc[1], 32'h0BAD_0001);
      chk("R6 epc1 used", 2, o_epc[2][31:0], 32'h0BAD_0001);
      pend_level = 4'd0;
      @(negedge clk); compare_all();
      for (int i = 0; i < NI; i++) chk("R8 single pulse", i, 32'(o_tk[i]), 32'd0);
      // randomised run compared every cycle
      for (int k = 0; k < 4000; k++) begin
         drive_random();
         @(negedge clk);
         compare_all();
      end
      if (n_dbl == 0 || n_high == 0 || n_l1 == 0) begin
         errors++;
         $display("FAIL R6 coverage: got dbl=%0d high=%0d l1=%0d expected all nonzero", n_dbl, n_high, n_l1);
      end
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule